// File: doc/BRIEF.md
# Burst SPI Master with Byte Queues

This block is a full-duplex serial peripheral master. Bytes the core wants to send wait in a 64-entry transmit queue. Every byte received from the slave lands in a 64-entry receive queue. The core writes the queue, picks a slave with a chip-select index, and pulses `start` with a byte count. The block then frames the whole burst under one chip-select assertion and shifts each byte MSB first. Afterwards it raises a one-cycle `done`.

The serial clock idle level, the clock phase and the chip-select active level come from static configuration inputs. The serial clock half period is `cfg_div + 1` system cycles. A byte is only started when the transmit queue has data and the receive queue has room. Otherwise the burst pauses with the serial clock parked at its idle level and chip select still asserted. It resumes by itself once the condition clears.

The controller has five states. `ST_IDLE` waits for a start. `ST_LOAD` holds chip select and waits for a byte to be available. `ST_SHIFT` produces the sixteen serial clock edges of one byte. `ST_TRAIL` holds chip select for one half period after the last edge. `ST_FINISH` is a one-cycle state with chip select released and `done` high.

The transitions are as follows:
- IDLE→LOAD is taken on `start` with a non-zero count.
- LOAD→SHIFT is taken when a byte can be moved.
- SHIFT→LOAD is taken after the last edge of a byte when more bytes remain.
- SHIFT→TRAIL is taken after the last edge of the final byte.
- TRAIL→FINISH is taken after one half period.
- FINISH→IDLE is taken unconditionally.

Top module: `spi_burst_master`

## Requirements
- R1: After reset `busy`=0, `done`=0, `tx_empty`=1, `rx_empty`=1, `tx_full`=0, `sclk` equals `cfg_cpol`, and every `cs_o` bit is at the inactive level, which is the inverse of `cfg_cs_high`.
- R2: Each queue holds 64 bytes in first-in first-out order. `tx_full` and `rx_full` are 1 when the queue holds 64 bytes. A push into a full queue is dropped.
- R3: Whenever no byte is being shifted (idle, or paused between bytes), `sclk` equals `cfg_cpol`.
- R4: Data moves MSB first in all four modes. The mode is set by `cfg_cpol` and `cfg_cpha`. Input is captured on rising `sclk` edges when `cfg_cpol`==`cfg_cpha`, and on falling edges otherwise. Output changes on the opposite edges. With `cfg_cpha`=0, bit 7 is on `mosi` before the first edge of a byte.
- R5: Only `cs_o[cfg_cs_sel]` is ever active. It is driven to `cfg_cs_high` during a burst, and all other bits stay at the inactive level.
- R6: Within a byte, consecutive `sclk` edges are exactly `cfg_div`+1 clock cycles apart.
- R7: Chip select becomes active at least `cfg_div`+1 cycles before the first `sclk` edge of a burst. It becomes inactive exactly `cfg_div`+1 cycles after the last edge.
- R8: `done` is high for exactly one cycle, in the first cycle chip select is inactive after a burst. `busy` falls in the following cycle.
- R9: If the transmit queue is empty when a byte is due, the burst pauses with chip select active and `sclk` idle. It continues when a byte is pushed.
- R10: If the receive queue is full when a byte is due, the burst pauses the same way. It continues when a byte is popped, and the receive queue is never overrun.
- R11: `start` is ignored while `busy` is 1, or when `burst_len` is 0.
- R12: A burst of L bytes shifts out exactly L bytes and pushes exactly L received bytes into the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: leading edge samples; 1: leading edge sets up |
| cfg_cs_high | input | 1 | 1: chip selects active high; 0: active low |
| cfg_cs_sel | input | CS_W (2) | Index of the chip select used by the burst |
| cfg_div | input | DIV_W (8) | Half period of `sclk` minus one, in clock cycles |
| start | input | 1 | Begin a burst (accepted in idle only) |
| burst_len | input | LEN_W (16) | Number of bytes in the burst |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | DATA_W (8) | Byte to send |
| tx_full | output | 1 | Transmit queue holds 64 bytes |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | DATA_W (8) | Head of the receive queue |
| rx_full | output | 1 | Receive queue holds 64 bytes |
| rx_empty | output | 1 | Receive queue is empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| cs_o | output | NUM_CS (4) | Chip-select lines |

## Verification
The assertions assume that the configuration inputs hold steady while `busy` is 1. They also assume that `rx_pop` and `tx_push` are pulses of one cycle. The bench changes the configuration only between bursts, after `busy` has fallen. It pops only when `rx_empty` is 0, except where a push into a full queue is deliberately tested. The sweep covers every mode, chip-select index and active level at three divider values. A bench slave model samples and drives on the edges the mode calls for, so any misplaced edge appears as wrong data on one side or the other.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_FINISH
    } sbm_state_t;
endpackage

// File: rtl/sbm_fifo.sv
module sbm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> full && $stable(wr_ptr)); // R2
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty && $stable(rd_ptr)); // R2
endmodule

// File: rtl/sbm_halfper.sv
module sbm_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!en)      cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && (div != '0)) |=> !tick); // R6
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int NUM_CS     = 4,
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 16,
    localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_cs_high,
    input  logic [CS_W-1:0]   cfg_cs_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              start,
    input  logic [LEN_W-1:0]  burst_len,
    output logic              busy,
    output logic              done,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_o
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);

    sbm_state_t        state_q, state_d;
    logic [LEN_W-1:0]  bytes_q;
    logic [EDGE_W-1:0] edge_q;
    logic              sclk_ph_q;
    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic [DATA_W-1:0] tx_head, rx_push_data;
    logic              tick, last_edge, is_lead, sample_now, setup_now;
    logic              can_load, rx_push, cs_act;

    sbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wr_data(tx_data),
        .pop(can_load), .rd_data(tx_head), .full(tx_full), .empty(tx_empty));

    sbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wr_data(rx_push_data),
        .pop(rx_pop), .rd_data(rx_data), .full(rx_full), .empty(rx_empty));

    sbm_halfper #(.DIV_W(DIV_W)) u_half (
        .clk(clk), .rst_n(rst_n),
        .en(state_q == ST_SHIFT || state_q == ST_TRAIL),
        .div(cfg_div), .tick(tick));

    // Edge scheduling: even edge index = leading edge of a bit cell
    assign is_lead    = ~edge_q[0];
    assign last_edge  = (state_q == ST_SHIFT) && tick && (edge_q == EDGE_W'(EDGES-1));
    assign sample_now = (state_q == ST_SHIFT) && tick && (is_lead ^ cfg_cpha);
    assign setup_now  = (state_q == ST_SHIFT) && tick && !(is_lead ^ cfg_cpha)
                        && !last_edge && !(cfg_cpha && edge_q == '0);
    assign can_load   = (state_q == ST_LOAD) && !tx_empty && !rx_full;
    assign rx_push    = last_edge;
    assign rx_push_data = cfg_cpha ? {rx_sh_q[DATA_W-2:0], miso} : rx_sh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && burst_len != '0) state_d = ST_LOAD;
            ST_LOAD:   if (can_load) state_d = ST_SHIFT;
            ST_SHIFT:  if (last_edge) state_d = (bytes_q == LEN_W'(1)) ? ST_TRAIL : ST_LOAD;
            ST_TRAIL:  if (tick) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q   <= '0;
            edge_q    <= '0;
            sclk_ph_q <= 1'b0;
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && start) bytes_q <= burst_len;
            else if (last_edge)              bytes_q <= bytes_q - 1'b1;
            if (state_q == ST_LOAD)          edge_q <= '0;
            else if (state_q == ST_SHIFT && tick) edge_q <= edge_q + 1'b1;
            if (state_q == ST_SHIFT && tick) sclk_ph_q <= ~sclk_ph_q;
            if (can_load)                    tx_sh_q <= tx_head;
            else if (setup_now)              tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            if (sample_now)                  rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
        end
    end

    always_comb begin
        cs_act = (state_q == ST_LOAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        sclk   = sclk_ph_q ^ cfg_cpol;
        mosi   = tx_sh_q[DATA_W-1];
        for (int i = 0; i < NUM_CS; i++)
            cs_o[i] = (cs_act && cfg_cs_sel == CS_W'(i)) ? cfg_cs_high : ~cfg_cs_high;
    end

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_LOAD) |-> (sclk == cfg_cpol)); // R3
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_o ^ {NUM_CS{~cfg_cs_high}}) <= 1); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R8
    AST_NO_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R10
    AST_STALL_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && (tx_empty || rx_full)) |=> $stable(sclk) && busy); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && start) |=> $stable(bytes_q) || $past(last_edge)); // R11
endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_high = 1'b0;
    logic [1:0] cfg_cs_sel = 2'd0;
    logic [7:0] cfg_div = 8'd0;
    logic start = 1'b0;
    logic [15:0] burst_len = 16'd0;
    logic busy, done, tx_full, tx_empty, rx_full, rx_empty, sclk, mosi, miso;
    logic tx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = 8'd0, rx_data;
    logic [3:0] cs_o;

    int total = 0, bad = 0, cyc = 0;
    int cur_b = 0, sl_idx = 0;
    logic [2:0] sl_bit = 3'd0;
    logic [7:0] sl_sh = 8'd0;
    logic [7:0] sl_rx [128];
    logic [7:0] sl_byte;

    always #2 clk = ~clk;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_cs_high(cfg_cs_high), .cfg_cs_sel(cfg_cs_sel), .cfg_div(cfg_div),
        .start(start), .burst_len(burst_len), .busy(busy), .done(done),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o));

    function automatic logic [7:0] tx_pat(input int b, input int k);
        return 8'((b * 53 + k * 29 + 7) & 255);
    endfunction
    function automatic logic [7:0] sl_pat(input int b, input int k);
        return 8'(((b * 17 + k * 101 + 3) & 255) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Slave model: samples on the mode's capture edge, presents the next bit right after
    logic sel_act;
    assign sel_act = (cs_o[cfg_cs_sel] == cfg_cs_high);
    always_comb sl_byte = sl_pat(cur_b, sl_idx);
    assign miso = sl_byte[3'd7 - sl_bit];

    always @(posedge sclk or negedge sclk) begin
        if (rst_n && sel_act && (sclk == (cfg_cpol == cfg_cpha))) begin
            sl_sh = {sl_sh[6:0], mosi};
            if (sl_bit == 3'd7) begin
                if (sl_idx < 128) sl_rx[sl_idx] = sl_sh;
                sl_idx = sl_idx + 1;
                sl_bit = 3'd0;
            end else begin
                sl_bit = sl_bit + 3'd1;
            end
        end
    end

    // Timing monitor, sampled away from the active edge
    logic prev_sclk = 1'b0, prev_act = 1'b0, first_pend = 1'b0;
    int e_cnt = 0, last_e = 0, cs_on = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int j = 0; j < 4; j++)
                if (j != int'(cfg_cs_sel))
                    chk(cs_o[j] == ~cfg_cs_high, "R5 unselected cs", cs_o[j], ~cfg_cs_high);
            if (!busy) begin
                chk(sclk == cfg_cpol, "R3 sclk idle", sclk, cfg_cpol);
                chk(!sel_act, "R5 cs idle", sel_act, 0);
            end
            if (done) chk(!sel_act, "R8 cs off at done", sel_act, 0);
            if (sel_act && !prev_act) begin
                cs_on = cyc; first_pend = 1'b1; e_cnt = 0;
            end
            if (!sel_act && prev_act) begin
                chk(cyc - last_e == int'(cfg_div) + 1, "R7 trail", cyc - last_e, int'(cfg_div) + 1);
                chk(done == 1'b1, "R8 done with release", done, 1);
            end
            if (sel_act && sclk != prev_sclk) begin
                e_cnt++;
                if (first_pend) begin
                    chk(cyc - cs_on >= int'(cfg_div) + 1, "R7 lead", cyc - cs_on, int'(cfg_div) + 1);
                    first_pend = 1'b0;
                end else if (e_cnt != 1) begin
                    chk(cyc - last_e == int'(cfg_div) + 1, "R6 half period", cyc - last_e, int'(cfg_div) + 1);
                end
                if (e_cnt == 16) e_cnt = 0;
                last_e = cyc;
            end
        end
        prev_sclk = sclk;
        prev_act  = rst_n && sel_act;
    end

    task automatic push_tx(input logic [7:0] d);
        tx_data = d; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic go(input int len);
        burst_len = 16'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R8 done seen", done, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy falls after done", busy, 0);
    endtask

    task automatic pop_chk(input logic [7:0] exp, input string req);
        chk(rx_data == exp, req, rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic new_slave(input int b);
        cur_b = b; sl_idx = 0; sl_bit = 3'd0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<190000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(cs_o == 4'hF, "R1 cs inactive", cs_o, 4'hF);
        chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
        chk(tx_empty && rx_empty && !tx_full, "R1 flags", {tx_empty, rx_empty, tx_full}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: modes x dividers x selects x cs level (R4 R5 R6 R7 R12)
        for (int m = 0; m < 4; m++)
            for (int di = 0; di < 3; di++)
                for (int s = 0; s < 4; s++)
                    for (int h = 0; h < 2; h++) begin
                        int b = ((m * 3 + di) * 4 + s) * 2 + h;
                        cfg_cpol = m[1]; cfg_cpha = m[0];
                        cfg_div = (di == 0) ? 8'd0 : (di == 1) ? 8'd1 : 8'd3;
                        cfg_cs_sel = 2'(s); cfg_cs_high = h[0];
                        @(negedge clk);
                        for (int k = 0; k < 3; k++) push_tx(tx_pat(b, k));
                        new_slave(b);
                        go(3);
                        wait_done();
                        chk(sl_idx == 3, "R12 byte count", sl_idx, 3);
                        for (int k = 0; k < 3; k++)
                            chk(sl_rx[k] == tx_pat(b, k), "R4 mosi data", sl_rx[k], tx_pat(b, k));
                        for (int k = 0; k < 3; k++) pop_chk(sl_pat(b, k), "R4 miso data");
                        chk(rx_empty && tx_empty, "R12 queues drained", {rx_empty, tx_empty}, 3);
                    end

        // R11: zero length and start while busy
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd1; cfg_cs_sel = 2'd2; cfg_cs_high = 1'b0;
        @(negedge clk);
        go(0);
        repeat (5) @(negedge clk);
        chk(busy == 0 && cs_o == 4'hF, "R11 zero length ignored", {busy, cs_o}, 4'hF);
        push_tx(8'hA1); push_tx(8'h3C);
        new_slave(100);
        go(2);
        repeat (10) @(negedge clk);
        go(5);
        wait_done();
        repeat (50) @(negedge clk);
        chk(busy == 0, "R11 start while busy ignored", busy, 0);
        chk(sl_idx == 2, "R11 only first burst ran", sl_idx, 2);
        pop_chk(sl_pat(100, 0), "R11 rx0");
        pop_chk(sl_pat(100, 1), "R11 rx1");

        // R9: pause on empty transmit queue
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 8'd1;
        @(negedge clk);
        push_tx(8'h81);
        new_slave(101);
        go(3);
        repeat (200) @(negedge clk);
        chk(busy == 1 && sel_act == 1, "R9 paused with cs held", {busy, sel_act}, 3);
        chk(sclk == cfg_cpol, "R9 sclk parked", sclk, cfg_cpol);
        chk(sl_idx == 1 && !rx_empty, "R9 one byte done", sl_idx, 1);
        push_tx(8'h18); push_tx(8'hF0);
        wait_done();
        chk(sl_idx == 3, "R9 resumed", sl_idx, 3);
        chk(sl_rx[1] == 8'h18 && sl_rx[2] == 8'hF0, "R9 resumed data", sl_rx[2], 8'hF0);
        for (int k = 0; k < 3; k++) pop_chk(sl_pat(101, k), "R9 rx data");

        // R2 and R10: queue depth, dropped push, pause on full receive queue
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd0; cfg_cs_sel = 2'd1;
        @(negedge clk);
        for (int k = 0; k < 64; k++) push_tx(tx_pat(102, k));
        chk(tx_full == 1, "R2 tx full at 64", tx_full, 1);
        push_tx(8'hEE);
        new_slave(102);
        go(64);
        wait_done();
        chk(rx_full == 1, "R2 rx full at 64", rx_full, 1);
        chk(tx_empty == 1, "R2 push into full tx dropped", tx_empty, 1);
        chk(sl_rx[63] == tx_pat(102, 63), "R2 last tx byte", sl_rx[63], tx_pat(102, 63));
        push_tx(8'h5C); push_tx(8'hC5);
        new_slave(103);
        go(2);
        repeat (100) @(negedge clk);
        chk(busy == 1 && sl_idx == 0, "R10 paused on full rx", sl_idx, 0);
        chk(sclk == cfg_cpol, "R10 sclk parked", sclk, cfg_cpol);
        pop_chk(sl_pat(102, 0), "R2 rx order 0");
        repeat (100) @(negedge clk);
        chk(busy == 1 && sl_idx == 1, "R10 one byte after pop", sl_idx, 1);
        pop_chk(sl_pat(102, 1), "R2 rx order 1");
        wait_done();
        chk(sl_idx == 2, "R10 resumed to end", sl_idx, 2);
        for (int k = 2; k < 64; k++) pop_chk(sl_pat(102, k), "R2 rx order");
        pop_chk(sl_pat(103, 0), "R10 rx after pause 0");
        pop_chk(sl_pat(103, 1), "R10 rx after pause 1");
        chk(rx_empty == 1, "R12 rx drained", rx_empty, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule